// File: doc/BRIEF.md
# Three-Operand Leading Zero Anticipator

This block looks at three aligned two's complement significands before they are reduced to a carry-save pair. From them it predicts how far the sum A+B+C must be shifted left to normalize it. The prediction is based on the per-bit digit sum of the three operands, which lies between 0 and 3. Each digit is re-encoded into zero, transfer and generate symbols using its lower neighbour. A leading-one indicator vector is built from those symbols, and a recursive leading-zero tree turns it into a shift count. The tree settles the most significant count bit first, so a normalization shifter can start on it early. The same symbols feed a priority chain that gives the sign of the sum. This lets the downstream adder produce a magnitude without having to complement its result afterwards.

The caller must leave headroom so that the true sum of the three signed N-bit operands fits in N signed bits. The count is measured against the sum itself when the sum is non-negative, and against its bitwise inverse when it is negative. The count may be one short of the exact value, and a later correction stage repairs that. Results are registered, and they appear one clock after an operand set is accepted.

Top module: `tri_lza`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high in the following cycle together with the result for those operands; otherwise `out_valid` is low.
- R2: While `rst_n` is low at a rising edge, the following cycle shows `out_valid`, `lz_count`, `lz_zero` and `sum_neg` all at 0.
- R3: For a non-negative sum S, `lz_count` equals the number of leading zero bits of S in N bits, or that number minus one.
- R4: For a negative sum S, `lz_count` equals the number of leading zero bits of the bitwise inverse of S in N bits, or that number minus one.
- R5: `lz_zero` is 1 exactly when `lz_count` equals N. This happens only when the sum is 0 or −1.
- R6: `sum_neg` is 1 exactly when the signed sum A+B+C is below zero. In particular, it is 0 when all three operand sign bits (bit N−1) are 0, and 1 when all three are 1.
- R7: Operands presented while `in_valid` is low change none of `lz_count`, `lz_zero` or `sum_neg`.
- R8: The count never exceeds N, and it stays below N whenever `lz_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set is valid this cycle |
| op_a | input | N | First operand, two's complement |
| op_b | input | N | Second operand, two's complement |
| op_c | input | N | Third operand, two's complement |
| out_valid | output | 1 | Result registers hold a fresh result |
| lz_count | output | $clog2(N+1) | Predicted leading-zero count (saturates at N) |
| lz_zero | output | 1 | Indicator vector was empty; count saturated |
| sum_neg | output | 1 | Sign of A+B+C |

## Verification
The count prediction and the sign decision come from the same symbol vector in the same cycle. The hardest cases are those where both depend on a long run of transfer symbols. Sums of 0 and −1 reached through cancellation, plus and minus powers of two, and operand triples that carry into the top bits are all driven back to back with random triples. A scoreboard compares each result against the exact sum: the sign must match exactly, and the count must fall within the allowed one-bit window of the true leading-zero count of the sum or of its inverse.

// File: rtl/tri_lza_pkg.sv
// Package tri_lza_pkg
// Shared symbol type for the three-operand leading zero anticipator and
// the helper that maps one carry-save bit pair onto a symbol.
// Assumes nothing beyond a single sum bit and a single carry bit per position.
package tri_lza_pkg;

    // One pre-encoded symbol: exactly one of the three flags is set.
    typedef struct packed {
        logic zr;   // both bits clear
        logic tr;   // bits differ
        logic gn;   // both bits set
    } lza_sym_t;

    // Build the symbol of one position from its sum bit and incoming carry bit.
    function automatic lza_sym_t make_sym(input logic sbit, input logic cbit);
        lza_sym_t r;
        r.zr = ~sbit & ~cbit;
        r.tr = sbit ^ cbit;
        r.gn = sbit & cbit;
        return r;
    endfunction

endpackage

// File: rtl/tri_lza_precode.sv
// Module tri_lza_precode
// Adds the three operand bits at every position into a digit 0..3 and
// expands it into one-hot indicators. It then forms the zero/transfer/generate
// symbol of each position from that position's digit and the digit one
// place lower. Position N is a virtual sign-extension position built from
// digit N-1. Assumes the operands are two's complement and share one alignment.
module tri_lza_precode
    import tri_lza_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic [N-1:0] c_in,
    output logic [N:0]   sym_z,
    output logic [N:0]   sym_t,
    output logic [N:0]   sym_g
);

    logic [N-1:0] dig_odd;    // digit is 1 or 3
    logic [N-1:0] dig_high;   // digit is 2 or 3 (carries upward)

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_digit
            logic [1:0] wsum;
            logic [3:0] ind;

            // Per-position digit and its one-hot indicators.
            always_comb begin
                wsum = {1'b0, a_in[i]} + {1'b0, b_in[i]} + {1'b0, c_in[i]};
                ind  = 4'b0001 << wsum;
                dig_odd[i]  = ind[1] | ind[3];
                dig_high[i] = ind[2] | ind[3];
            end
        end

        for (i = 0; i <= N; i++) begin : g_sym
            lza_sym_t s;
            logic     sb;
            logic     cb;

            // Symbol of position i from digits i and i-1 (virtual at both ends).
            always_comb begin
                sb = (i == N) ? dig_odd[N-1]  : dig_odd[i];
                cb = (i == 0) ? 1'b0          : dig_high[i-1];
                s  = make_sym(sb, cb);
                sym_z[i] = s.zr;
                sym_t[i] = s.tr;
                sym_g[i] = s.gn;
            end
        end
    endgenerate

endmodule

// File: rtl/tri_lza_indicator.sv
// Module tri_lza_indicator
// Builds the leading-one indicator vector. Bit i looks at the transfer flag
// one place up and at the zero/generate flags of positions i and i-1. The
// first set bit from the top lies on the leading significant bit of the sum
// or one place above it. Below position 0 a virtual zero symbol is assumed.
module tri_lza_indicator #(
    parameter int N = 16
) (
    input  logic [N:0]   sym_z,
    input  logic [N:0]   sym_t,
    input  logic [N:0]   sym_g,
    output logic [N-1:0] ind_f
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_f
            logic zlo;
            logic glo;

            // Indicator bit i from the symbol window (i+1, i, i-1).
            always_comb begin
                zlo = (i == 0) ? 1'b1 : sym_z[i-1];
                glo = (i == 0) ? 1'b0 : sym_g[i-1];
                ind_f[i] = ( sym_t[i+1] & ((sym_g[i] & ~zlo) | (sym_z[i] & ~glo)))
                         | (~sym_t[i+1] & ((sym_z[i] & ~zlo) | (sym_g[i] & ~glo)));
            end
        end
    endgenerate

endmodule

// File: rtl/tri_lza_sign.sv
// Module tri_lza_sign
// Decides the sign of the sum from the same symbols. From the top, it finds the
// first position whose symbol is not a transfer: if it is a zero, or if there is
// none, the comparison term is set. The sum is negative when the extension symbol
// is a generate, or when it is a transfer and the comparison term is set.
// Assumes the true sum fits in N signed bits.
module tri_lza_sign #(
    parameter int N = 16
) (
    input  logic [N:0] sym_z,
    input  logic [N:0] sym_t,
    input  logic [N:0] sym_g,
    output logic       neg
);

    logic cmp;
    logic run_t;

    // Priority chain over positions N-1 down to 0.
    always_comb begin
        cmp   = 1'b0;
        run_t = 1'b1;
        for (int k = N - 1; k >= 0; k--) begin
            cmp   = cmp | (run_t & sym_z[k]);
            run_t = run_t & sym_t[k];
        end
        cmp = cmp | run_t;
        neg = sym_g[N] | (sym_t[N] & cmp);
    end

endmodule

// File: rtl/tri_lza_lzd.sv
// Module tri_lza_lzd
// Recursive leading-zero detector. Each node merges the found flag and partial
// count of its upper and lower halves. The top count bit is simply "upper half
// empty", so it settles first. Assumes W is a power of two, at least 2.
module tri_lza_lzd #(
    parameter int W = 16
) (
    input  logic [W-1:0]         vec,
    output logic                 found,
    output logic [$clog2(W)-1:0] pos
);

    localparam int H  = W / 2;
    localparam int HB = (H > 1) ? $clog2(H) : 1;

    generate
        if (W == 2) begin : g_leaf
            // Two-bit leaf: count is 0 when the upper bit is set.
            always_comb begin
                found = vec[1] | vec[0];
                pos   = ~vec[1];
            end
        end else begin : g_node
            logic          hi_found;
            logic          lo_found;
            logic [HB-1:0] hi_pos;
            logic [HB-1:0] lo_pos;

            tri_lza_lzd #(.W(H)) u_hi (
                .vec   (vec[W-1:H]),
                .found (hi_found),
                .pos   (hi_pos)
            );

            tri_lza_lzd #(.W(H)) u_lo (
                .vec   (vec[H-1:0]),
                .found (lo_found),
                .pos   (lo_pos)
            );

            // Merge halves: upper half wins when it holds a set bit.
            always_comb begin
                found = hi_found | lo_found;
                pos   = hi_found ? {1'b0, hi_pos} : {1'b1, lo_pos};
            end
        end
    endgenerate

endmodule

// File: rtl/tri_lza.sv
// Module tri_lza (top)
// Three-operand leading zero anticipator with sign decision and one register
// stage. The count saturates at N with lz_zero set when the indicator vector is
// empty. Assumes two's complement operands whose true sum fits in N signed
// bits, and N >= 4.
module tri_lza #(
    parameter int N = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [N-1:0]           op_a,
    input  logic [N-1:0]           op_b,
    input  logic [N-1:0]           op_c,
    output logic                   out_valid,
    output logic [$clog2(N+1)-1:0] lz_count,
    output logic                   lz_zero,
    output logic                   sum_neg
);

    localparam int CW = $clog2(N + 1);
    localparam int PB = $clog2(N);
    localparam int P  = 1 << PB;
    localparam logic [CW-1:0] SAT = CW'(N);

    logic [N:0]    sym_z;
    logic [N:0]    sym_t;
    logic [N:0]    sym_g;
    logic [N-1:0]  ind_f;
    logic [P-1:0]  ind_pad;
    logic          tree_found;
    logic [PB-1:0] tree_pos;
    logic          neg_c;
    logic [CW-1:0] cnt_c;

    tri_lza_precode #(.N(N)) u_pre (
        .a_in  (op_a),
        .b_in  (op_b),
        .c_in  (op_c),
        .sym_z (sym_z),
        .sym_t (sym_t),
        .sym_g (sym_g)
    );

    tri_lza_indicator #(.N(N)) u_ind (
        .sym_z (sym_z),
        .sym_t (sym_t),
        .sym_g (sym_g),
        .ind_f (ind_f)
    );

    tri_lza_sign #(.N(N)) u_sgn (
        .sym_z (sym_z),
        .sym_t (sym_t),
        .sym_g (sym_g),
        .neg   (neg_c)
    );

    // Pad the indicator to a power of two with empty low bits.
    generate
        if (P > N) begin : g_pad
            assign ind_pad = {ind_f, {(P - N){1'b0}}};
        end else begin : g_nopad
            assign ind_pad = ind_f;
        end
    endgenerate

    tri_lza_lzd #(.W(P)) u_lzd (
        .vec   (ind_pad),
        .found (tree_found),
        .pos   (tree_pos)
    );

    // Saturate the count when no indicator bit is set.
    always_comb begin
        cnt_c = tree_found ? CW'(tree_pos) : SAT;
    end

    // Output register stage, loaded only for accepted operand sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            lz_count  <= '0;
            lz_zero   <= 1'b0;
            sum_neg   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                lz_count <= cnt_c;
                lz_zero  <= ~tree_found;
                sum_neg  <= neg_c;
            end
        end
    end

endmodule

// File: rtl/tri_lza_chk.sv
// Module tri_lza_chk
// Assertion checker bound to tri_lza. It observes the ports only.
module tri_lza_chk #(
    parameter int N = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [N-1:0]           op_a,
    input logic [N-1:0]           op_b,
    input logic [N-1:0]           op_c,
    input logic                   out_valid,
    input logic [$clog2(N+1)-1:0] lz_count,
    input logic                   lz_zero,
    input logic                   sum_neg
);

    localparam int CW = $clog2(N + 1);

    // R1: an accepted set yields a result in the next cycle.
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no result without an accepted set.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: reset clears the result valid.
    a_r2_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid && lz_count == '0 && !sum_neg && !lz_zero);

    // R5: the zero flag goes with a saturated count.
    a_r5_zero_sat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && lz_zero |-> lz_count == CW'(N));

    // R8: the count stays in range.
    a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !lz_zero |-> lz_count < CW'(N));

    // R6: three non-negative operands give a non-negative sum.
    a_r6_all_pos: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !op_a[N-1] && !op_b[N-1] && !op_c[N-1] |=> !sum_neg);

    // R6: three negative operands give a negative sum.
    a_r6_all_neg: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_a[N-1] && op_b[N-1] && op_c[N-1] |=> sum_neg);

    // R7: results hold while no set is accepted.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !in_valid |=> $stable(lz_count) && $stable(sum_neg) && $stable(lz_zero));

endmodule

bind tri_lza tri_lza_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .out_valid (out_valid),
    .lz_count  (lz_count),
    .lz_zero   (lz_zero),
    .sum_neg   (sum_neg)
);

// File: tb/tri_lza_bench.sv
// Scoreboard bench for tri_lza: the driver queues expected sums, the monitor
// pops them as results appear and checks count window, sign, flag and latency.
module tri_lza_bench;

    localparam int N  = 16;
    localparam int CW = $clog2(N + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [N-1:0]  op_a = '0;
    logic signed [N-1:0]  op_b = '0;
    logic signed [N-1:0]  op_c = '0;
    logic                 out_valid;
    logic [CW-1:0]        lz_count;
    logic                 lz_zero;
    logic                 sum_neg;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int sum;
        int tlz;
        int stamp;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tri_lza #(.N(N)) u_tri_lza (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .out_valid (out_valid),
        .lz_count  (lz_count),
        .lz_zero   (lz_zero),
        .sum_neg   (sum_neg)
    );

    // Exact leading-zero count of the sum, or of its inverse when negative.
    function automatic int ref_lz(input int s);
        logic [N-1:0] v;
        int n;
        v = (s < 0) ? ~s[N-1:0] : s[N-1:0];
        n = 0;
        for (int k = N - 1; k >= 0; k--) begin
            if (v[k]) break;
            n++;
        end
        return n;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: present one operand set and queue its expected result.
    task automatic drive(input int a, input int b, input int c);
        exp_t e;
        @(negedge clk);
        op_a = N'(a);
        op_b = N'(b);
        op_c = N'(c);
        in_valid = 1'b1;
        e.sum = a + b + c;
        e.tlz = ref_lz(e.sum);
        e.stamp = cyc;
        q.push_back(e);
    endtask

    // Monitor: compare each result with the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check("R1 unexpected result", 1'b0, 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R1 latency", cyc == e.stamp + 1, cyc - e.stamp, 1);
                if (e.sum >= 0)
                    check("R3 count window", (lz_count == e.tlz) || (lz_count + 1 == e.tlz),
                          int'(lz_count), e.tlz);
                else
                    check("R4 count window", (lz_count == e.tlz) || (lz_count + 1 == e.tlz),
                          int'(lz_count), e.tlz);
                check("R6 sign", sum_neg == (e.sum < 0), int'(sum_neg), int'(e.sum < 0));
                check("R5 flag matches saturation", lz_zero == (lz_count == CW'(N)),
                      int'(lz_zero), int'(lz_count == CW'(N)));
                if (lz_zero)
                    check("R5 flag only for 0 or -1", e.tlz == N, e.tlz, N);
                check("R8 count range", lz_count <= CW'(N), int'(lz_count), N);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] hold_cnt;
        logic          hold_neg;
        logic          hold_zero;

        // R2: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset valid", out_valid == 1'b0, int'(out_valid), 0);
        check("R2 reset count", lz_count == '0, int'(lz_count), 0);
        check("R2 reset sign", sum_neg == 1'b0, int'(sum_neg), 0);
        rst_n = 1'b1;

        // Directed corner sums.
        drive(0, 0, 0);
        drive(-1, 0, 0);
        drive(1, -1, 0);
        drive(1, 0, 0);
        drive(3, -1, -1);
        drive(8191, 8191, 8191);
        drive(-8192, -8192, -8192);
        drive(8191, -8191, 1);
        drive(-1, -1, 1);
        drive(-1, -1, -1);
        for (int k = 0; k < 13; k++) begin
            drive(1 << k, 0, 0);
            drive(-(1 << k), 0, 0);
            drive(1 << k, 1 << k, -(1 << k));
            drive((1 << k) - 1, 1, 0);
            drive(-(1 << k), -1, 1);
        end

        // Random operand triples with headroom for the sum.
        for (int r = 0; r < 400; r++) begin
            drive($urandom_range(0, 16383) - 8192,
                  $urandom_range(0, 16383) - 8192,
                  $urandom_range(0, 16383) - 8192);
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 all results seen", q.size() == 0, q.size(), 0);

        // R7: operands presented without in_valid leave the outputs untouched.
        hold_cnt  = lz_count;
        hold_neg  = sum_neg;
        hold_zero = lz_zero;
        for (int h = 0; h < 4; h++) begin
            op_a = N'(h * 1111 - 2000);
            op_b = N'(-h * 777);
            op_c = N'(h + 5);
            @(negedge clk);
            check("R7 idle valid", out_valid == 1'b0, int'(out_valid), 0);
            check("R7 idle count hold", lz_count == hold_cnt, int'(lz_count), int'(hold_cnt));
            check("R7 idle sign hold", sum_neg == hold_neg, int'(sum_neg), int'(hold_neg));
            check("R7 idle flag hold", lz_zero == hold_zero, int'(lz_zero), int'(hold_zero));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule